// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block steps a device through one lifecycle state change. After reset it settles in an idle state. A transition request moves it through a fixed series of steps. It hands the core clock over to a bypass source, bumps a transition counter and has an external programmer store it, and asks outside logic whether the requested move is allowed. It then has a hasher digest the unlock token, asks a wipe agent to erase the protected flash region, and compares the captured digest with the expected token twice, once in each of two separate cycles. Only after that does it have the programmer write the new lifecycle state. Every failure ends in a post-transition lockout state with a sticky failure flag. Nothing leaves that state except escalation or reset.

Two redundant escalation inputs each force the machine into a terminal escalation state from any operational state. A scrap indication seen while idle parks the machine in a terminal scrap state. The state register uses a sparse single-error-detecting encoding, and the current state code is driven out on a port. Any code outside the legal set is read as an invalid state, whose only exit is escalation. The programmer, hasher and wipe agent are reached through simple level request / done handshakes.

Top module: `lc_seq_fsm`

## Requirements
- R1: `state_o` carries a 7-bit code for state index k: Reset=1, Idle=2, ClkMux=3, CntIncr=4, CntProg=5, TransCheck=6, TokenHash=7, FlashRma=8, TokenCheck0=9, TokenCheck1=10, TransProg=11, PostTrans=12, Scrap=13, Escalate=14, Invalid=15. With d=k[3:0], the code is {d, d1^d2^d3, d0^d2^d3, d0^d1^d3}. While reset is held, the state is Reset, every request output and `cnt_prog_val_o` are zero, and `fail_o` is 0.
- R2: On the first clock edge after reset is released, Reset moves to Idle.
- R3: From Idle, `scrap_lc_i` moves to Scrap and wins over `trans_req_i`. Otherwise `trans_req_i` moves to ClkMux, and ClkMux moves to CntIncr one cycle later. `clk_byp_o` is high in every state from ClkMux through TransProg and low in Reset, Idle and PostTrans.
- R4: In CntIncr, an all-ones `cnt_i` moves to PostTrans and sets `fail_o`. Any other value moves to CntProg and loads `cnt_prog_val_o` with `cnt_i`+1.
- R5: CntProg and TransProg hold `prog_req_o` high. `prog_tgt_o` is 0 in CntProg and 1 in TransProg. Both states wait for `prog_done_i` or `prog_err_i`. An error moves to PostTrans and sets `fail_o`. Done moves CntProg to TransCheck, and moves TransProg to PostTrans with `fail_o` left at 0.
- R6: In TransCheck, `trans_ok_i`=0 moves to PostTrans and sets `fail_o`. `trans_ok_i`=1 moves to TokenHash.
- R7: TokenHash holds `hash_req_o` high until `hash_done_i` or `hash_err_i`. An error moves to PostTrans and sets `fail_o`. Done captures `hash_i` and moves to FlashRma. FlashRma holds `wipe_req_o` high until `wipe_ack_i`, then moves to TokenCheck0.
- R8: TokenCheck0 and TokenCheck1 each take exactly one cycle and compare the captured digest with `token_i`. A mismatch in either state moves to PostTrans and sets `fail_o`. A match moves TokenCheck0 to TokenCheck1 and TokenCheck1 to TransProg.
- R9: In any state from Idle through PostTrans, or in Invalid, `esc_a_i` or `esc_b_i` on its own moves the machine to Escalate on the next edge, ahead of every other transition.
- R10: Scrap and Escalate never change until reset. PostTrans changes only to Escalate. Once set, `fail_o` stays set until reset. No request, token or handshake input changes any of this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| esc_a_i | input | 1 | Escalation input, first copy |
| esc_b_i | input | 1 | Escalation input, second copy |
| trans_req_i | input | 1 | Transition request, sampled in Idle |
| scrap_lc_i | input | 1 | Current lifecycle state is a scrap state |
| cnt_i | input | CNT_W | Current transition counter value |
| trans_ok_i | input | 1 | Requested transition is allowed |
| prog_done_i | input | 1 | Programmer finished a write |
| prog_err_i | input | 1 | Programmer reported a write error |
| hash_done_i | input | 1 | Hasher digest ready on `hash_i` |
| hash_err_i | input | 1 | Hasher error |
| hash_i | input | HASH_W | Token digest from the hasher |
| token_i | input | HASH_W | Expected token digest |
| wipe_ack_i | input | 1 | Flash wipe finished |
| state_o | output | 7 | Current state code (R1) |
| clk_byp_o | output | 1 | Clock bypass select |
| prog_req_o | output | 1 | Programmer write request |
| prog_tgt_o | output | 1 | Write target: 0 counter, 1 lifecycle state |
| cnt_prog_val_o | output | CNT_W | Counter value to program |
| hash_req_o | output | 1 | Hash request |
| wipe_req_o | output | 1 | Flash wipe request |
| fail_o | output | 1 | Sticky transition failure flag |

## Verification
Escalation and normal sequencing can fall in the same cycle: an escalation input can rise on the same edge where a handshake completes, for example `esc_b_i` together with `prog_done_i` in CntProg. The bench drives both in one cycle. It passes only if the next state is Escalate and not the step the handshake would have led to. Escalation combined with a transition request in Idle, and escalation in the wipe step, are judged the same way.

// File: rtl/lc_seq_pkg.sv
`timescale 1ns/1ps
package lc_seq_pkg;

  localparam int ST_W = 7;

  // Sparse codes: 4 index bits followed by 3 parity bits (distance 3)
  typedef enum logic [ST_W-1:0] {
    ST_RESET   = 7'b0001011,
    ST_IDLE    = 7'b0010101,
    ST_CLKMUX  = 7'b0011110,
    ST_CNTINC  = 7'b0100110,
    ST_CNTPROG = 7'b0101101,
    ST_XCHECK  = 7'b0110011,
    ST_TOKHASH = 7'b0111000,
    ST_WIPE    = 7'b1000111,
    ST_TOKCMP0 = 7'b1001100,
    ST_TOKCMP1 = 7'b1010010,
    ST_XPROG   = 7'b1011001,
    ST_POST    = 7'b1100001,
    ST_SCRAP   = 7'b1101010,
    ST_ESC     = 7'b1110100,
    ST_INVALID = 7'b1111111
  } lc_st_e;

  // Code word for a 4-bit state index
  function automatic logic [ST_W-1:0] st_code(input logic [3:0] d);
    return {d, d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
  endfunction

  function automatic logic is_legal(input logic [ST_W-1:0] c);
    return (c[ST_W-1:3] != 4'd0) && (c == st_code(c[ST_W-1:3]));
  endfunction

  // States from which an escalation input takes effect
  function automatic logic can_escalate(input lc_st_e s);
    return s inside {ST_IDLE, ST_CLKMUX, ST_CNTINC, ST_CNTPROG, ST_XCHECK,
                     ST_TOKHASH, ST_WIPE, ST_TOKCMP0, ST_TOKCMP1, ST_XPROG,
                     ST_POST, ST_INVALID};
  endfunction

endpackage

// File: rtl/lc_seq_next.sv
`timescale 1ns/1ps
module lc_seq_next
  import lc_seq_pkg::*;
(
  input  lc_st_e cur_i,
  input  logic   esc_any_i,
  input  logic   scrap_i,
  input  logic   req_i,
  input  logic   cnt_sat_i,
  input  logic   ok_i,
  input  logic   pdone_i,
  input  logic   perr_i,
  input  logic   hdone_i,
  input  logic   herr_i,
  input  logic   wack_i,
  input  logic   match_i,
  output lc_st_e nxt_o,
  output logic   fail_set_o,
  output logic   cap_o,
  output logic   cnt_ld_o
);

  always_comb begin
    nxt_o      = cur_i;
    fail_set_o = 1'b0;
    cap_o      = 1'b0;
    cnt_ld_o   = 1'b0;
    case (cur_i)
      ST_RESET: nxt_o = ST_IDLE;
      ST_IDLE: begin
        if (scrap_i)    nxt_o = ST_SCRAP;
        else if (req_i) nxt_o = ST_CLKMUX;
      end
      ST_CLKMUX: nxt_o = ST_CNTINC;
      ST_CNTINC: begin
        if (cnt_sat_i) begin
          nxt_o      = ST_POST;
          fail_set_o = 1'b1;
        end else begin
          nxt_o    = ST_CNTPROG;
          cnt_ld_o = 1'b1;
        end
      end
      ST_CNTPROG: begin
        if (perr_i) begin
          nxt_o      = ST_POST;
          fail_set_o = 1'b1;
        end else if (pdone_i) begin
          nxt_o = ST_XCHECK;
        end
      end
      ST_XCHECK: begin
        if (ok_i) begin
          nxt_o = ST_TOKHASH;
        end else begin
          nxt_o      = ST_POST;
          fail_set_o = 1'b1;
        end
      end
      ST_TOKHASH: begin
        if (herr_i) begin
          nxt_o      = ST_POST;
          fail_set_o = 1'b1;
        end else if (hdone_i) begin
          nxt_o = ST_WIPE;
          cap_o = 1'b1;
        end
      end
      ST_WIPE: if (wack_i) nxt_o = ST_TOKCMP0;
      ST_TOKCMP0, ST_TOKCMP1: begin
        if (!match_i) begin
          nxt_o      = ST_POST;
          fail_set_o = 1'b1;
        end else begin
          nxt_o = (cur_i == ST_TOKCMP0) ? ST_TOKCMP1 : ST_XPROG;
        end
      end
      ST_XPROG: begin
        if (perr_i) begin
          nxt_o      = ST_POST;
          fail_set_o = 1'b1;
        end else if (pdone_i) begin
          nxt_o = ST_POST;
        end
      end
      ST_POST, ST_SCRAP, ST_ESC: nxt_o = cur_i;
      ST_INVALID: nxt_o = ST_ESC;
      default: nxt_o = ST_INVALID;
    endcase

    if (esc_any_i && can_escalate(cur_i)) begin
      nxt_o      = ST_ESC;
      fail_set_o = 1'b0;
      cap_o      = 1'b0;
      cnt_ld_o   = 1'b0;
    end
  end

endmodule

// File: rtl/lc_seq_tokchk.sv
`timescale 1ns/1ps
module lc_seq_tokchk #(
  parameter int HASH_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [HASH_W-1:0] hash_i,
  input  logic [HASH_W-1:0] token_i,
  output logic              match_o
);

  localparam int LANE_W = HASH_W / LANES;

  logic [HASH_W-1:0] digest_q;
  logic [LANES-1:0]  lane_eq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    digest_q <= '0;
    else if (cap_i) digest_q <= hash_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (digest_q[g*LANE_W +: LANE_W] == token_i[g*LANE_W +: LANE_W]);
  end

  assign match_o = &lane_eq;

endmodule

// File: rtl/lc_seq_outdec.sv
`timescale 1ns/1ps
module lc_seq_outdec
  import lc_seq_pkg::*;
(
  input  lc_st_e st_i,
  output logic   clk_byp_o,
  output logic   prog_req_o,
  output logic   prog_tgt_o,
  output logic   hash_req_o,
  output logic   wipe_req_o
);

  always_comb begin
    clk_byp_o  = st_i inside {ST_CLKMUX, ST_CNTINC, ST_CNTPROG, ST_XCHECK,
                              ST_TOKHASH, ST_WIPE, ST_TOKCMP0, ST_TOKCMP1, ST_XPROG};
    prog_req_o = (st_i == ST_CNTPROG) || (st_i == ST_XPROG);
    prog_tgt_o = (st_i == ST_XPROG);
    hash_req_o = (st_i == ST_TOKHASH);
    wipe_req_o = (st_i == ST_WIPE);
  end

endmodule

// File: rtl/lc_seq_fsm.sv
`timescale 1ns/1ps
module lc_seq_fsm
  import lc_seq_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int HASH_W    = 32,
  parameter int CMP_LANES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              esc_a_i,
  input  logic              esc_b_i,
  input  logic              trans_req_i,
  input  logic              scrap_lc_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              trans_ok_i,
  input  logic              prog_done_i,
  input  logic              prog_err_i,
  input  logic              hash_done_i,
  input  logic              hash_err_i,
  input  logic [HASH_W-1:0] hash_i,
  input  logic [HASH_W-1:0] token_i,
  input  logic              wipe_ack_i,
  output logic [ST_W-1:0]   state_o,
  output logic              clk_byp_o,
  output logic              prog_req_o,
  output logic              prog_tgt_o,
  output logic [CNT_W-1:0]  cnt_prog_val_o,
  output logic              hash_req_o,
  output logic              wipe_req_o,
  output logic              fail_o
);

  lc_st_e           state_q, state_d;
  logic             fail_q;
  logic [CNT_W-1:0] cnt_val_q;

  // Named internal events, observed by the bound checker
  logic esc_any, cnt_sat, tok_match, fail_set, hash_cap, cnt_ld;

  assign esc_any = esc_a_i | esc_b_i;
  assign cnt_sat = &cnt_i;

  lc_seq_next u_next (
    .cur_i      (state_q),
    .esc_any_i  (esc_any),
    .scrap_i    (scrap_lc_i),
    .req_i      (trans_req_i),
    .cnt_sat_i  (cnt_sat),
    .ok_i       (trans_ok_i),
    .pdone_i    (prog_done_i),
    .perr_i     (prog_err_i),
    .hdone_i    (hash_done_i),
    .herr_i     (hash_err_i),
    .wack_i     (wipe_ack_i),
    .match_i    (tok_match),
    .nxt_o      (state_d),
    .fail_set_o (fail_set),
    .cap_o      (hash_cap),
    .cnt_ld_o   (cnt_ld)
  );

  lc_seq_tokchk #(
    .HASH_W (HASH_W),
    .LANES  (CMP_LANES)
  ) u_tokchk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (hash_cap),
    .hash_i  (hash_i),
    .token_i (token_i),
    .match_o (tok_match)
  );

  lc_seq_outdec u_outdec (
    .st_i       (state_q),
    .clk_byp_o  (clk_byp_o),
    .prog_req_o (prog_req_o),
    .prog_tgt_o (prog_tgt_o),
    .hash_req_o (hash_req_o),
    .wipe_req_o (wipe_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_RESET;
      fail_q    <= 1'b0;
      cnt_val_q <= '0;
    end else begin
      state_q <= state_d;
      if (fail_set) fail_q <= 1'b1;
      if (cnt_ld)   cnt_val_q <= cnt_i + CNT_W'(1);
    end
  end

  assign state_o        = state_q;
  assign fail_o         = fail_q;
  assign cnt_prog_val_o = cnt_val_q;

endmodule

// File: rtl/lc_seq_fsm_chk.sv
`timescale 1ns/1ps
module lc_seq_fsm_chk
  import lc_seq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             esc_any,
  input logic             tok_match,
  input logic             cnt_ld,
  input logic [ST_W-1:0]  state_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cnt_prog_val_o,
  input logic             prog_req_o,
  input logic             hash_req_o,
  input logic             wipe_req_o,
  input logic             fail_o
);

  p_legal_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_legal(state_o));

  p_reset_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_RESET |=> state_o == ST_IDLE);

  p_cnt_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_ld |=> cnt_prog_val_o == CNT_W'($past(cnt_i) + 1'b1));

  p_req_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_req_o, hash_req_o, wipe_req_o}));

  p_cmp0_fail_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_TOKCMP0 && !tok_match && !esc_any) |=> state_o == ST_POST && fail_o);

  p_cmp1_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_TOKCMP1 |=> state_o != ST_TOKCMP1);

  p_esc_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc_any && can_escalate(lc_st_e'(state_o))) |=> state_o == ST_ESC);

  p_post_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_POST && !esc_any) |=> state_o == ST_POST);

  p_term_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SCRAP || state_o == ST_ESC) |=> $stable(state_o));

  p_fail_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o);

endmodule

bind lc_seq_fsm lc_seq_fsm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .esc_any        (esc_any),
  .tok_match      (tok_match),
  .cnt_ld         (cnt_ld),
  .state_o        (state_o),
  .cnt_i          (cnt_i),
  .cnt_prog_val_o (cnt_prog_val_o),
  .prog_req_o     (prog_req_o),
  .hash_req_o     (hash_req_o),
  .wipe_req_o     (wipe_req_o),
  .fail_o         (fail_o)
);

// File: tb/lc_seq_fsm_bench.sv
`timescale 1ns/1ps
module lc_seq_fsm_bench;

  localparam int CNT_W  = 5;
  localparam int HASH_W = 32;
  localparam logic [HASH_W-1:0] HKEY = 32'hC0DE_5A17;

  // Vector: req scrap ok pdone | perr hdone herr wack | match esc_a esc_b | next state | fail
  localparam int NVEC = 16;
  localparam logic [15:0] VEC [NVEC] = '{
    16'b1000_0000_000_0011_0,  // Idle -> ClkMux
    16'b0000_0000_000_0100_0,  // -> CntIncr
    16'b0000_0000_000_0101_0,  // -> CntProg
    16'b0000_0000_000_0101_0,  // wait for programmer
    16'b0001_0000_000_0110_0,  // done -> TransCheck
    16'b0010_0000_000_0111_0,  // ok -> TokenHash
    16'b0000_0000_000_0111_0,  // wait for hasher
    16'b0000_0100_000_1000_0,  // digest -> FlashRma
    16'b0000_0000_000_1000_0,  // wait for wipe
    16'b0000_0001_000_1001_0,  // ack -> TokenCheck0
    16'b0000_0000_100_1010_0,  // match -> TokenCheck1
    16'b0000_0000_100_1011_0,  // match -> TransProg
    16'b0001_0000_000_1100_0,  // done -> PostTrans, no failure
    16'b1011_1101_100_1100_0,  // busy inputs, PostTrans holds
    16'b0000_0000_010_1110_0,  // esc_a -> Escalate
    16'b1001_0101_101_1110_0   // Escalate holds
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic esc_a, esc_b, req, scrap, ok, pdone, perr, hdone, herr, wack;
  logic [CNT_W-1:0]  cnt;
  logic [HASH_W-1:0] hash, token;

  logic [6:0]       state_o;
  logic             clk_byp_o, prog_req_o, prog_tgt_o, hash_req_o, wipe_req_o, fail_o;
  logic [CNT_W-1:0] cnt_prog_val_o;

  int  checks = 0;
  int  errors = 0;
  bit  reported = 1'b0;

  always #10 clk = ~clk;

  lc_seq_fsm #(.CNT_W(CNT_W), .HASH_W(HASH_W)) u_lc_seq_fsm (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .esc_a_i        (esc_a),
    .esc_b_i        (esc_b),
    .trans_req_i    (req),
    .scrap_lc_i     (scrap),
    .cnt_i          (cnt),
    .trans_ok_i     (ok),
    .prog_done_i    (pdone),
    .prog_err_i     (perr),
    .hash_done_i    (hdone),
    .hash_err_i     (herr),
    .hash_i         (hash),
    .token_i        (token),
    .wipe_ack_i     (wack),
    .state_o        (state_o),
    .clk_byp_o      (clk_byp_o),
    .prog_req_o     (prog_req_o),
    .prog_tgt_o     (prog_tgt_o),
    .cnt_prog_val_o (cnt_prog_val_o),
    .hash_req_o     (hash_req_o),
    .wipe_req_o     (wipe_req_o),
    .fail_o         (fail_o)
  );

  // State code from the index, written from the requirement text
  function automatic logic [6:0] enc(input int k);
    logic [3:0] d;
    d = k[3:0];
    return {d[3], d[2], d[1], d[0], d[1] ^ d[2] ^ d[3], d[0] ^ d[2] ^ d[3], d[0] ^ d[1] ^ d[3]};
  endfunction

  task automatic chk(input bit good, input string rq, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_st(input string rq, input int k);
    chk(state_o == enc(k), rq, int'(state_o), int'(enc(k)));
  endtask

  task automatic chk_fail(input string rq, input bit exp);
    chk(fail_o == exp, rq, int'(fail_o), int'(exp));
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic clr();
    esc_a = 0; esc_b = 0; req = 0; scrap = 0; ok = 0; pdone = 0; perr = 0;
    hdone = 0; herr = 0; wack = 0; cnt = CNT_W'(5); hash = HKEY; token = HKEY;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clr();
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  // Walk n steps of the successful path from Idle
  task automatic walk(input int n);
    for (int i = 1; i <= n; i++) begin
      clr();
      case (i)
        1: req = 1'b1;
        4: pdone = 1'b1;
        5: ok = 1'b1;
        6: hdone = 1'b1;
        7: wack = 1'b1;
        default: ;
      endcase
      tick();
    end
    clr();
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL run-timeout actual=hung expected=finished");
    report();
  end

  initial begin
    clr();
    rst_n = 1'b0;
    tick();
    tick();
    // R1: reset values
    chk_st("R1 reset state", 1);
    chk({clk_byp_o, prog_req_o, hash_req_o, wipe_req_o, fail_o} == 5'b0 && cnt_prog_val_o == '0,
        "R1 outputs in reset", int'({clk_byp_o, prog_req_o, hash_req_o, wipe_req_o, fail_o}), 0);
    rst_n = 1'b1;
    tick();
    chk_st("R2 reset to idle", 2);
    chk(clk_byp_o == 1'b0, "R3 bypass low in idle", int'(clk_byp_o), 0);

    // Table walk: full successful transition, lockout, escalation
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] v;
      v = VEC[i];
      req = v[15]; scrap = v[14]; ok = v[13]; pdone = v[12];
      perr = v[11]; hdone = v[10]; herr = v[9]; wack = v[8];
      token = v[7] ? HKEY : ~HKEY;
      esc_a = v[6]; esc_b = v[5];
      tick();
      chk_st($sformatf("R3-path vector %0d state", i), int'(v[4:1]));
      chk_fail($sformatf("R10 vector %0d fail flag", i), v[0]);
      if (v[4:1] == 4'd5) begin
        chk(cnt_prog_val_o == CNT_W'(6), "R4 counter value", int'(cnt_prog_val_o), 6);
        chk(prog_req_o && !prog_tgt_o, "R5 counter write request", int'({prog_req_o, prog_tgt_o}), 2);
      end
      if (v[4:1] == 4'd11)
        chk(prog_req_o && prog_tgt_o, "R5 state write request", int'({prog_req_o, prog_tgt_o}), 3);
      if (v[4:1] == 4'd7)
        chk(hash_req_o, "R7 hash request", int'(hash_req_o), 1);
      if (v[4:1] == 4'd8)
        chk(wipe_req_o, "R7 wipe request", int'(wipe_req_o), 1);
      if (v[4:1] == 4'd12)
        chk(!clk_byp_o, "R3 bypass low in PostTrans", int'(clk_byp_o), 0);
    end

    // R3 scrap wins over request; R10 scrap ignores escalation
    do_reset();
    scrap = 1'b1; req = 1'b1;
    tick();
    chk_st("R3 scrap over request", 13);
    clr();
    esc_b = 1'b1; req = 1'b1; pdone = 1'b1;
    tick();
    chk_st("R10 scrap holds", 13);

    // R4 saturated counter
    do_reset();
    walk(1);
    chk(clk_byp_o, "R3 bypass high in ClkMux", int'(clk_byp_o), 1);
    tick();
    chk_st("R3 ClkMux to CntIncr", 4);
    cnt = '1;
    tick();
    chk_st("R4 saturated counter", 12);
    chk_fail("R4 fail on saturation", 1'b1);
    clr();
    req = 1'b1; pdone = 1'b1; hdone = 1'b1; wack = 1'b1;
    tick();
    chk_st("R10 PostTrans holds", 12);
    chk_fail("R10 fail stays set", 1'b1);

    // R5 counter write error
    do_reset();
    chk_fail("R1 fail cleared by reset", 1'b0);
    walk(3);
    perr = 1'b1;
    tick();
    chk_st("R5 counter write error", 12);
    chk_fail("R5 fail on counter write error", 1'b1);

    // R6 disallowed transition
    do_reset();
    walk(4);
    ok = 1'b0;
    tick();
    chk_st("R6 transition refused", 12);
    chk_fail("R6 fail on refusal", 1'b1);

    // R7 hasher error
    do_reset();
    walk(5);
    herr = 1'b1;
    tick();
    chk_st("R7 hash error", 12);
    chk_fail("R7 fail on hash error", 1'b1);

    // R8 first comparison mismatch
    do_reset();
    walk(7);
    token = ~HKEY;
    tick();
    chk_st("R8 first compare mismatch", 12);
    chk_fail("R8 fail on first mismatch", 1'b1);

    // R8 second comparison mismatch
    do_reset();
    walk(8);
    chk_st("R8 in TokenCheck1", 10);
    token = HKEY ^ 32'h0001_0000;
    tick();
    chk_st("R8 second compare mismatch", 12);
    chk_fail("R8 fail on second mismatch", 1'b1);

    // R5 state write error
    do_reset();
    walk(9);
    perr = 1'b1;
    tick();
    chk_st("R5 state write error", 12);
    chk_fail("R5 fail on state write error", 1'b1);

    // R9 escalation in the same cycle as a handshake completion
    do_reset();
    walk(3);
    pdone = 1'b1; esc_b = 1'b1;
    tick();
    chk_st("R9 esc_b beats programmer done", 14);
    clr();
    req = 1'b1; pdone = 1'b1;
    tick();
    chk_st("R10 Escalate holds", 14);

    // R9 escalation from Idle with a request
    do_reset();
    req = 1'b1; esc_a = 1'b1;
    tick();
    chk_st("R9 esc_a beats request in Idle", 14);

    // R9 escalation during wipe
    do_reset();
    walk(6);
    esc_a = 1'b1; wack = 1'b1;
    tick();
    chk_st("R9 esc_a beats wipe ack", 14);

    clr();
    report();
  end

endmodule